// File: doc/BRIEF.md
# Paged Address Translator with Lookup Buffer and Table Walker

This block turns a processor's virtual address into a physical address for a memory system with a single-level page table. Each request carries a 16-bit virtual address and an access kind (read, write or execute). The block first looks in a small 4-set, 2-way buffer of recent translations. On a hit it answers without touching memory. On a miss it makes one read of the page table entry through a simple request/response memory port. The entry address is built from a base register and the virtual page number.

The response carries the physical address, a page-fault flag and a protection-fault flag. An entry with its valid bit clear gives a page fault and is not cached. A valid entry fetched on a miss is cached, so a retried access hits. Permission bits are checked on every access, whether the entry came from the buffer or from memory. A flush input, or any write of the base register, empties the buffer in one cycle. Only one translation is in flight at a time.

Top module: `mmu_xlate`

## Requirements
- R1: The virtual address splits into a 10-bit page number (bits 15:6) and a 6-bit offset (bits 5:0). A successful translation returns a physical address whose upper 8 bits are the entry's page number and whose low 6 bits are the request offset, unchanged.
- R2: A request that hits in the buffer makes no memory read. Its response arrives in the second cycle after the request is accepted.
- R3: On a miss the block makes exactly one memory read. The read address is base register + 2 × page number. The response arrives in the second cycle after the memory reply. Entry format: bit 15 valid, bit 14 read allowed, bit 13 write allowed, bit 12 execute allowed, bits 7:0 physical page number.
- R4: A fetched entry with bit 15 clear gives page fault = 1, protection fault = 0 and physical address 0. The entry is not cached, so a retry walks memory again.
- R5: Access code 0 (read) needs bit 14, code 1 (write) needs bit 13 and code 2 (execute) needs bit 12. Code 3 is always denied. A denial gives protection fault = 1 with physical address 0. The check applies on buffer hits and on walks alike.
- R6: A valid entry fetched on a miss is cached, even if the access was denied, so a later access to the same page hits.
- R7: Page-number bits 1:0 select the set and bits 9:2 form the tag. Two pages that share a set are held at once, one in each way.
- R8: A fill uses an invalid way first. When both ways are valid, it replaces the way used less recently, tracked by one bit per set that hits and fills update.
- R9: A flush pulse empties the whole buffer, so the next access to any page walks memory.
- R10: A write of the base register empties the buffer. Later walks use the new base.
- R11: req_ready is high only when no translation is in flight. A memory read request stays asserted with a steady address until the memory accepts it.
- R12: After reset, req_ready = 1, rsp_valid = 0, mem_rd_valid = 0, the base register is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 14 | Physical address (0 on any fault) |
| rsp_page_fault | output | 1 | Page table entry was not valid |
| rsp_prot_fault | output | 1 | Access kind not permitted |
| mem_rd_valid | output | 1 | Page table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 14 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 16 | Page table entry |
| ptbr_wr_en | input | 1 | Write the page table base register |
| ptbr_wr_data | input | 14 | New base value |
| flush | input | 1 | Empty the translation buffer |

## Verification
A buffer hit answers exactly two cycles after the accepting edge: one cycle to look up and one to register the result. A walk with a memory that replies one cycle after accepting the read answers four cycles after acceptance. The bench counts falling edges from the accepting edge to rsp_valid and compares that count with 2 or 4, depending on whether the vector expects a walk. It also compares how many memory reads were made during the request, and their address. All outputs are sampled on the falling edge, so each response is read in the cycle its register updates.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } acc_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } perm_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WALK_REQ,
      ST_WALK_WAIT,
      ST_RESP
   } xlate_st_e;

endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
   import mmu_pkg::*;
(
   input  acc_e  acc,
   input  perm_t perm,
   output logic  allow
);

   always_comb begin
      unique case (acc)
         ACC_READ:  allow = perm.rd;
         ACC_WRITE: allow = perm.wr;
         ACC_EXEC:  allow = perm.ex;
         default:   allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
   import mmu_pkg::*;
#(
   parameter int SET_W = 2,
   parameter int WAYS  = 2,
   parameter int TAG_W = 8,
   parameter int PPN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             lk_touch,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output perm_t            lk_perm,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [PPN_W-1:0] fill_ppn,
   input  perm_t            fill_perm
);

   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   generate
      if (WAYS < 1 || WAYS > 2) begin : g_bad_ways
         $error("mmu_tlb: one replacement bit per set supports 1 or 2 ways");
      end
      if (SET_W < 1) begin : g_bad_sets
         $error("mmu_tlb: SET_W must be at least 1");
      end
   endgenerate

   logic [WAYS-1:0]  vld_q  [SETS];
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
   perm_t            perm_q [SETS][WAYS];
   logic [SETS-1:0]  lru_q;

   logic [WAYS-1:0]  hit_w;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim;

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_way_cmp
         assign hit_w[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      end
   endgenerate

   always_comb begin
      lk_ppn  = '0;
      lk_perm = '0;
      hit_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_w[i]) begin
            lk_ppn  = ppn_q[lk_set][i];
            lk_perm = perm_q[lk_set][i];
            hit_way = WAY_W'(i);
         end
      end
   end
   assign lk_hit = |hit_w;

   generate
      if (WAYS == 1) begin : g_victim_direct
         assign victim = '0;
      end else begin : g_victim_lru
         always_comb begin
            if (!vld_q[fill_set][0])      victim = 1'b0;
            else if (!vld_q[fill_set][1]) victim = 1'b1;
            else                          victim = lru_q[fill_set];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_set][victim]  <= fill_tag;
         ppn_q[fill_set][victim]  <= fill_ppn;
         perm_q[fill_set][victim] <= fill_perm;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
         lru_q <= '0;
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (fill_en) begin
         vld_q[fill_set][victim] <= 1'b1;
         lru_q[fill_set]         <= (WAYS > 1) ? !victim[0] : 1'b0;
      end else if (lk_touch && lk_hit) begin
         lru_q[lk_set]           <= (WAYS > 1) ? !hit_way[0] : 1'b0;
      end
   end

   // R7: a page is never held in two ways of the same set
   a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_w));

   // R9: the cycle after a flush nothing can hit
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
   import mmu_pkg::*;
#(
   parameter int VA_W  = 16,
   parameter int PA_W  = 14,
   parameter int OFS_W = 6,
   parameter int SET_W = 2,
   parameter int WAYS  = 2,
   parameter int PTE_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_acc,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_page_fault,
   output logic            rsp_prot_fault,
   output logic            mem_rd_valid,
   input  logic            mem_rd_ready,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   input  logic            ptbr_wr_en,
   input  logic [PA_W-1:0] ptbr_wr_data,
   input  logic            flush
);

   localparam int VPN_W   = VA_W - OFS_W;
   localparam int PPN_W   = PA_W - OFS_W;
   localparam int TAG_W   = VPN_W - SET_W;
   localparam int PTE_B_W = $clog2(PTE_W / 8);
   localparam int B_VLD   = PTE_W - 1;
   localparam int B_RD    = PTE_W - 2;
   localparam int B_WR    = PTE_W - 3;
   localparam int B_EX    = PTE_W - 4;

   generate
      if (PPN_W < 1 || PPN_W > PTE_W - 4) begin : g_bad_ppn
         $error("mmu_xlate: page number does not fit below the flag bits");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("mmu_xlate: set index consumes the whole page number");
      end
      if (PA_W < VPN_W + PTE_B_W) begin : g_bad_walk
         $error("mmu_xlate: entry address cannot reach the whole table");
      end
      if (PTE_W % 8 != 0) begin : g_bad_pte
         $error("mmu_xlate: entry width must be whole bytes");
      end
   endgenerate

   xlate_st_e         st_q;
   logic [VA_W-1:0]   vaddr_q;
   acc_e              acc_q;
   logic [PA_W-1:0]   ptbr_q;
   logic [PA_W-1:0]   paddr_q;
   logic              pf_q;
   logic              prot_q;

   logic [VPN_W-1:0]  vpn;
   logic [OFS_W-1:0]  ofs;
   logic              tlb_hit;
   logic [PPN_W-1:0]  tlb_ppn;
   perm_t             tlb_perm;
   perm_t             pte_perm;
   perm_t             chk_perm;
   logic              allow;
   logic              pte_vld;
   logic              fill_en;
   logic              lookup_hit;

   assign vpn = vaddr_q[VA_W-1:OFS_W];
   assign ofs = vaddr_q[OFS_W-1:0];

   assign pte_vld  = mem_rsp_data[B_VLD];
   assign pte_perm = '{rd: mem_rsp_data[B_RD], wr: mem_rsp_data[B_WR], ex: mem_rsp_data[B_EX]};
   assign chk_perm = (st_q == ST_WALK_WAIT) ? pte_perm : tlb_perm;

   generate
      if (PTE_W - 5 >= PPN_W) begin : g_spare_bits
         logic unused_pte_bits;
         assign unused_pte_bits = ^mem_rsp_data[PTE_W-5:PPN_W];
      end
   endgenerate

   assign lookup_hit = (st_q == ST_LOOKUP) && tlb_hit;
   assign fill_en    = (st_q == ST_WALK_WAIT) && mem_rsp_valid && pte_vld;

   mmu_tlb #(
      .SET_W (SET_W),
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
   ) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush || ptbr_wr_en),
      .lk_set    (vpn[SET_W-1:0]),
      .lk_tag    (vpn[VPN_W-1:SET_W]),
      .lk_touch  (st_q == ST_LOOKUP),
      .lk_hit    (tlb_hit),
      .lk_ppn    (tlb_ppn),
      .lk_perm   (tlb_perm),
      .fill_en   (fill_en),
      .fill_set  (vpn[SET_W-1:0]),
      .fill_tag  (vpn[VPN_W-1:SET_W]),
      .fill_ppn  (mem_rsp_data[PPN_W-1:0]),
      .fill_perm (pte_perm)
   );

   mmu_perm u_perm (
      .acc   (acc_q),
      .perm  (chk_perm),
      .allow (allow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptbr_q <= '0;
      end else if (ptbr_wr_en) begin
         ptbr_q <= ptbr_wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         vaddr_q <= '0;
         acc_q   <= ACC_READ;
         paddr_q <= '0;
         pf_q    <= 1'b0;
         prot_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  acc_q   <= acc_e'(req_acc);
                  st_q    <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (tlb_hit) begin
                  pf_q    <= 1'b0;
                  prot_q  <= !allow;
                  paddr_q <= allow ? {tlb_ppn, ofs} : '0;
                  st_q    <= ST_RESP;
               end else begin
                  st_q    <= ST_WALK_REQ;
               end
            end
            ST_WALK_REQ: begin
               if (mem_rd_ready) st_q <= ST_WALK_WAIT;
            end
            ST_WALK_WAIT: begin
               if (mem_rsp_valid) begin
                  pf_q    <= !pte_vld;
                  prot_q  <= pte_vld && !allow;
                  paddr_q <= (pte_vld && allow) ? {mem_rsp_data[PPN_W-1:0], ofs} : '0;
                  st_q    <= ST_RESP;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (st_q == ST_IDLE);
   assign rsp_valid      = (st_q == ST_RESP);
   assign rsp_paddr      = paddr_q;
   assign rsp_page_fault = pf_q;
   assign rsp_prot_fault = prot_q;
   assign mem_rd_valid   = (st_q == ST_WALK_REQ);
   assign mem_rd_addr    = ptbr_q + PA_W'({vpn, {PTE_B_W{1'b0}}});

   // R2: a buffer hit is never followed by a memory read
   a_r2_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_hit |=> !mem_rd_valid);

   // R4: a page fault carries no address and no protection fault
   a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_page_fault) |-> (rsp_paddr == '0 && !rsp_prot_fault));

   // R1: the offset reaches the physical address unchanged
   a_r1_offset_through: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |->
         (rsp_paddr[OFS_W-1:0] == vaddr_q[OFS_W-1:0]));

   // R5: access code 3 is denied whenever the entry is valid
   a_r5_none_denied: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && acc_q == ACC_NONE && !rsp_page_fault) |-> rsp_prot_fault);

   // R11: no new request is taken while a response or read is pending
   a_r11_busy_response: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || mem_rd_valid) |-> !req_ready);

   // R11: a read request holds its address until accepted
   a_r11_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

endmodule

// File: tb/mmu_xlate_tb.sv
`timescale 1ns/1ps
module mmu_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        rsp_valid;
   logic [13:0] rsp_paddr;
   logic        rsp_page_fault;
   logic        rsp_prot_fault;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b1;
   logic [13:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [15:0] mem_rsp_data = '0;
   logic        ptbr_wr_en = 1'b0;
   logic [13:0] ptbr_wr_data = '0;
   logic        flush = 1'b0;

   int          n_chk = 0;
   int          n_fail = 0;
   int          mem_reads = 0;
   logic [13:0] last_addr = '0;
   logic [13:0] base = '0;

   always #4 clk = ~clk;

   mmu_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .ptbr_wr_en(ptbr_wr_en),
      .ptbr_wr_data(ptbr_wr_data), .flush(flush)
   );

   // page table content as a function of the entry byte address
   function automatic logic [15:0] pte_at(input logic [13:0] a);
      logic [12:0] x;
      x = a[13:1];
      pte_at = {(x[4:0] != 5'd7), 1'b1, x[0], x[1], 4'b0, x[11:4] ^ 8'h3C};
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_rd_valid && mem_rd_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= pte_at(mem_rd_addr);
         mem_reads     <= mem_reads + 1;
         last_addr     <= mem_rd_addr;
      end
   end

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // vector: {vaddr, access code, expect walk}
   localparam int NV = 18;
   localparam logic [18:0] VEC [NV] = '{
      {16'h0405, 2'd0, 1'b1},  // R1 R3 first touch of page 0x010
      {16'h0405, 2'd1, 1'b0},  // R5 write denied on a hit
      {16'h043F, 2'd0, 1'b0},  // R6 refetched page hits
      {16'h0811, 2'd0, 1'b1},  // R7 same set, second way
      {16'h0400, 2'd0, 1'b0},  // R7 first way still present
      {16'h0C22, 2'd0, 1'b1},  // R8 evicts page 0x020
      {16'h0401, 2'd0, 1'b0},  // R8 survivor hits
      {16'h0833, 2'd0, 1'b1},  // R8 evicted page walks again
      {16'h0C01, 2'd0, 1'b1},  // R8
      {16'h0402, 2'd0, 1'b1},  // R8
      {16'h01C4, 2'd0, 1'b1},  // R4 invalid entry
      {16'h01C4, 2'd0, 1'b1},  // R4 not cached
      {16'h00C9, 2'd2, 1'b1},  // R5 execute allowed
      {16'h00C9, 2'd1, 1'b0},  // R5 write allowed on hit
      {16'h00CA, 2'd3, 1'b0},  // R5 code 3 denied on hit
      {16'h0047, 2'd2, 1'b1},  // R5 execute denied on walk
      {16'h0047, 2'd0, 1'b0},  // R6 denied walk still cached
      {16'h0C3E, 2'd0, 1'b0}   // R8 most recent fill kept
   };

   task automatic xlate(input logic [15:0] va, input logic [1:0] acc,
                        input logic exp_walk, input string req);
      int          n;
      int          r0;
      logic [13:0] ea;
      logic [15:0] pte;
      logic        ok;
      logic        e_pf;
      logic        e_prot;
      logic [13:0] e_pa;
      ea  = base + {3'b0, va[15:6], 1'b0};
      pte = pte_at(ea);
      case (acc)
         2'd0: ok = pte[14];
         2'd1: ok = pte[13];
         2'd2: ok = pte[12];
         default: ok = 1'b0;
      endcase
      e_pf   = !pte[15];
      e_prot = pte[15] && !ok;
      e_pa   = (pte[15] && ok) ? {pte[7:0], va[5:0]} : 14'h0;

      @(negedge clk);
      req_vaddr = va;
      req_acc   = acc;
      req_valid = 1'b1;
      r0 = mem_reads;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      chk(!req_ready, "R11", "ready while busy", req_ready, 0);
      while (!rsp_valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk(n == (exp_walk ? 4 : 2), exp_walk ? "R3" : "R2", "response latency", n, exp_walk ? 4 : 2);
      chk(mem_reads - r0 == (exp_walk ? 1 : 0), req, "memory reads", mem_reads - r0, exp_walk ? 1 : 0);
      if (exp_walk)
         chk(last_addr == ea, "R3", "entry address", last_addr, ea);
      chk(rsp_page_fault == e_pf, req, "page fault", rsp_page_fault, e_pf);
      chk(rsp_prot_fault == e_prot, req, "protection fault", rsp_prot_fault, e_prot);
      chk(rsp_paddr == e_pa, req, "physical address", rsp_paddr, e_pa);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(req_ready == 1'b1, "R12", "req_ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
      chk(mem_rd_valid == 1'b0, "R12", "mem_rd_valid after reset", mem_rd_valid, 0);
      chk(mem_rd_addr == 14'h0, "R12", "base zero after reset", mem_rd_addr, 0);

      // program base, R10 flush side effect harmless on empty buffer
      ptbr_wr_en = 1'b1; ptbr_wr_data = 14'h1000;
      @(negedge clk);
      ptbr_wr_en = 1'b0; base = 14'h1000;

      for (int i = 0; i < NV; i++) begin
         xlate(VEC[i][18:3], VEC[i][2:1], VEC[i][0], $sformatf("R1/vec%0d", i));
      end

      // R9 flush empties the buffer
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      xlate(16'h0C3E, 2'd0, 1'b1, "R9");
      xlate(16'h0C3E, 2'd0, 1'b0, "R9");

      // R10 new base flushes and is used
      ptbr_wr_en = 1'b1; ptbr_wr_data = 14'h2000;
      @(negedge clk);
      ptbr_wr_en = 1'b0; base = 14'h2000;
      xlate(16'h00C9, 2'd2, 1'b1, "R10");
      xlate(16'h00C9, 2'd0, 1'b0, "R10");
      xlate(16'h0C3E, 2'd0, 1'b1, "R10");

      // R11 memory stall holds the read request
      @(negedge clk);
      mem_rd_ready = 1'b0;
      req_vaddr = 16'h0405; req_acc = 2'd0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_rd_valid == 1'b1, "R11", "read held while stalled", mem_rd_valid, 1);
      chk(mem_rd_addr == 14'h2020, "R11", "stalled read address", mem_rd_addr, 14'h2020);
      mem_rd_ready = 1'b1;
      repeat (4) @(negedge clk);
      chk(req_ready == 1'b1, "R11", "idle after stalled walk", req_ready, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule